// File: doc/BRIEF.md
# Page-Directory Entry Check and Update

This block performs the first, directory-level step of a two-level linear-to-physical address translation for a single access. A request carries a 32-bit linear address, a read/write flag, the current privilege level (0 to 3) and the directory base address. The block computes where the directory entry sits, fetches it over a single-beat memory port, and validates it. If the access is allowed and the entry's accessed or dirty flag must change, it writes the entry back with a read-modify-write.

It then pulses `done` with one of three results. The first is a physical address, when the entry maps a 4 MB page directly. The second is a page-table base, when the entry points at a table of 4 KB pages. The third is a page fault with a cause code. The software-owned bits and the global, cache-disable and writethrough bits are copied to an attribute output; they are never interpreted or modified.

The memory port holds `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` steady until the memory answers with a one-cycle `mem_ack`. On a read, `mem_rdata` is valid in that same `mem_ack` cycle. A new request is taken only while the block is idle, which begins the cycle after `done`.

Top module: `pde_walker`

## Requirements
- R1: The entry is read from the address formed by the directory base with bits 11..0 cleared, plus linear address bits 31..22 times 4.
- R2: An entry with bit 0 clear gives fault code 1, and the block performs no memory write for that access.
- R3: An entry with bit 7 set and no fault gives result kind 0, with the address formed from entry bits 31..22 and linear address bits 21..0.
- R4: An entry with bit 7 clear and no fault gives result kind 1, with the address formed from entry bits 31..12 and 12 zero bits.
- R5: An entry with bits 0 and 7 set and any of bits 21..12 set gives fault code 2.
- R6: An entry with bit 2 set, accessed at privilege level 3, gives fault code 3.
- R6: Bit 2 set does not cause a fault at privilege levels 0 to 2.
- R7: A write to an entry with bit 1 clear gives fault code 4.
- R8: When several fault causes apply, the reported code follows the priority not-present, then reserved, then privilege, then write protection. A fault always has result kind 2. Code 0 means no fault.
- R9: A successful access leaves bit 5 (accessed) set in the stored entry.
- R10: A successful write to a 4 MB entry sets bit 6 (dirty) in the stored entry.
- R10: A 4 KB entry always keeps its bit 6 unchanged.
- R11: Exactly one write-back occurs, before `done`, when bit 5 or bit 6 changes. No write occurs when neither changes or when the access faults.
- R12: The attribute output is {entry[11:9], entry[8], entry[4], entry[3]}, and every stored bit other than 5 and 6 is left unchanged.
- R13: After reset, `done` and `mem_req` are low. `done` is a one-cycle pulse, and a `req_valid` seen while an access is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start an access (taken only when idle) |
| req_lin_addr | input | 32 | Linear address of the access |
| req_write | input | 1 | 1 for write, 0 for read or fetch |
| req_cpl | input | 2 | Current privilege level |
| dir_base | input | 32 | Directory base address (low 12 bits ignored) |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address of the entry |
| mem_wdata | output | 32 | Updated entry on a write |
| mem_rdata | input | 32 | Entry read data, valid with mem_ack |
| mem_ack | input | 1 | One-cycle completion of the current request |
| done | output | 1 | One-cycle pulse, results valid |
| res_kind | output | 2 | 0 large-page address, 1 table base, 2 fault |
| res_addr | output | 32 | Result address (0 on fault) |
| fault_code | output | 3 | 0 none, 1 absent, 2 reserved, 3 privilege, 4 write-protect |
| attr_out | output | 6 | Passed-through entry attribute bits |

## Verification
The assertions assume that the memory answers each request with exactly one `mem_ack` pulse, raised only while `mem_req` is high. They also assume that the request inputs matter only in the idle cycle where `req_valid` is sampled. The bench memory model acknowledges one cycle after it sees a request that is not already being acknowledged, so no acknowledgement can arrive unasked. The bench also drives `req_valid` during a busy access, which confirms that such pulses are dropped rather than queued.

// File: rtl/pde_pkg.sv
package pde_pkg;
   localparam int ENTRY_W = 32;
   localparam int BIT_PRES  = 0;
   localparam int BIT_WR    = 1;
   localparam int BIT_SUP   = 2;
   localparam int BIT_WT    = 3;
   localparam int BIT_NC    = 4;
   localparam int BIT_ACC   = 5;
   localparam int BIT_DIRTY = 6;
   localparam int BIT_BIG   = 7;
   localparam int BIT_GLB   = 8;
   localparam int SW_LO     = 9;
   localparam int SW_HI     = 11;
   localparam int ATTR_W    = (SW_HI - SW_LO + 1) + 3;
   localparam logic [1:0] LVL_USER = 2'd3;

   typedef enum logic [2:0] {
      FLT_NONE   = 3'd0,
      FLT_ABSENT = 3'd1,
      FLT_RSVD   = 3'd2,
      FLT_PRIV   = 3'd3,
      FLT_WPROT  = 3'd4
   } flt_e;

   typedef enum logic [1:0] {
      RK_BIG   = 2'd0,
      RK_TABLE = 2'd1,
      RK_FAULT = 2'd2
   } rk_e;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_RD   = 3'd1,
      ST_EVAL = 3'd2,
      ST_WR   = 3'd3,
      ST_DONE = 3'd4
   } st_e;
endpackage

// File: rtl/pde_addr_gen.sv
module pde_addr_gen #(
   parameter int ADDR_W      = 32,
   parameter int PAGE_SHIFT  = 12,
   parameter int DIR_SHIFT   = 22,
   parameter int ENTRY_BYTES = 4
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [ADDR_W-1:0] lin,
   output logic [ADDR_W-1:0] ent_addr
);
   localparam int IDX_W = ADDR_W - DIR_SHIFT;
   localparam int EB_W  = $clog2(ENTRY_BYTES);

   generate
      if (IDX_W + EB_W != PAGE_SHIFT) begin : g_bad_geom
         $error("directory index and entry size must fill one page");
      end
      if (ENTRY_BYTES * 8 != pde_pkg::ENTRY_W) begin : g_bad_entry
         $error("entry size must match entry width");
      end
      if (EB_W == 0) begin : g_bad_eb
         $error("entry must span more than one byte");
      end
   endgenerate

   logic [IDX_W-1:0] dir_idx;
   assign dir_idx  = lin[ADDR_W-1:DIR_SHIFT];
   assign ent_addr = {base[ADDR_W-1:PAGE_SHIFT], dir_idx, {EB_W{1'b0}}};
endmodule

// File: rtl/pde_check.sv
module pde_check
   import pde_pkg::*;
#(
   parameter int PAGE_SHIFT = 12,
   parameter int DIR_SHIFT  = 22
) (
   input  logic [ENTRY_W-1:0] entry,
   input  logic               is_write,
   input  logic [1:0]         cpl,
   output flt_e               code
);
   localparam int RSV_W = DIR_SHIFT - PAGE_SHIFT;

   generate
      if (RSV_W < 0) begin : g_bad_rsv
         $error("large-page shift must not be below small-page shift");
      end
   endgenerate

   logic rsv_any;

   generate
      if (RSV_W > 0) begin : g_rsv
         logic [RSV_W-1:0] rsv_bits;
         for (genvar i = 0; i < RSV_W; i++) begin : g_bit
            assign rsv_bits[i] = entry[PAGE_SHIFT + i];
         end
         assign rsv_any = |rsv_bits;
      end else begin : g_no_rsv
         assign rsv_any = 1'b0;
      end
   endgenerate

   logic is_big, sup_only, wr_ok;
   assign is_big   = entry[BIT_BIG];
   assign sup_only = entry[BIT_SUP];
   assign wr_ok    = entry[BIT_WR];

   always_comb begin
      if (!entry[BIT_PRES])                  code = FLT_ABSENT;
      else if (is_big && rsv_any)            code = FLT_RSVD;
      else if (sup_only && cpl == LVL_USER)  code = FLT_PRIV;
      else if (is_write && !wr_ok)           code = FLT_WPROT;
      else                                   code = FLT_NONE;
   end
endmodule

// File: rtl/pde_update.sv
module pde_update
   import pde_pkg::*;
#(
   parameter int PAGE_SHIFT = 12,
   parameter int DIR_SHIFT  = 22
) (
   input  logic [ENTRY_W-1:0] entry,
   input  logic [ENTRY_W-1:0] lin,
   input  logic               is_write,
   input  flt_e               code,
   output logic [ENTRY_W-1:0] new_entry,
   output logic               need_wb,
   output rk_e                kind,
   output logic [ENTRY_W-1:0] res_addr,
   output logic [ATTR_W-1:0]  attr
);
   logic               is_big;
   logic [ENTRY_W-1:0] set_mask;

   assign is_big = entry[BIT_BIG];

   always_comb begin
      set_mask = '0;
      set_mask[BIT_ACC] = 1'b1;
      if (is_big && is_write) set_mask[BIT_DIRTY] = 1'b1;
   end

   assign new_entry = entry | set_mask;
   assign need_wb   = (code == FLT_NONE) && (new_entry != entry);

   always_comb begin
      if (code != FLT_NONE) begin
         kind     = RK_FAULT;
         res_addr = '0;
      end else if (is_big) begin
         kind     = RK_BIG;
         res_addr = {entry[ENTRY_W-1:DIR_SHIFT], lin[DIR_SHIFT-1:0]};
      end else begin
         kind     = RK_TABLE;
         res_addr = {entry[ENTRY_W-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};
      end
   end

   assign attr = {entry[SW_HI:SW_LO], entry[BIT_GLB], entry[BIT_NC], entry[BIT_WT]};
endmodule

// File: rtl/pde_walker.sv
module pde_walker
   import pde_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int PAGE_SHIFT  = 12,
   parameter int DIR_SHIFT   = 22,
   parameter int ENTRY_BYTES = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_valid,
   input  logic [ADDR_W-1:0]     req_lin_addr,
   input  logic                  req_write,
   input  logic [1:0]            req_cpl,
   input  logic [ADDR_W-1:0]     dir_base,
   output logic                  mem_req,
   output logic                  mem_we,
   output logic [ADDR_W-1:0]     mem_addr,
   output logic [ENTRY_W-1:0]    mem_wdata,
   input  logic [ENTRY_W-1:0]    mem_rdata,
   input  logic                  mem_ack,
   output logic                  done,
   output logic [1:0]            res_kind,
   output logic [ADDR_W-1:0]     res_addr,
   output logic [2:0]            fault_code,
   output logic [ATTR_W-1:0]     attr_out
);
   generate
      if (ADDR_W != ENTRY_W) begin : g_bad_width
         $error("address width must equal entry width");
      end
   endgenerate

   st_e                st_q;
   logic [ADDR_W-1:0]  lin_q, ent_addr_q, ent_addr_d, res_addr_q;
   logic               wr_q;
   logic [1:0]         cpl_q;
   logic [ENTRY_W-1:0] entry_q, wdata_q, upd_entry;
   flt_e               chk_code, code_q;
   rk_e                upd_kind, kind_q;
   logic               upd_wb;
   logic [ADDR_W-1:0]  upd_addr;
   logic [ATTR_W-1:0]  upd_attr, attr_q;

   pde_addr_gen #(
      .ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT),
      .DIR_SHIFT(DIR_SHIFT), .ENTRY_BYTES(ENTRY_BYTES)
   ) addr_i (
      .base(dir_base), .lin(req_lin_addr), .ent_addr(ent_addr_d)
   );

   pde_check #(.PAGE_SHIFT(PAGE_SHIFT), .DIR_SHIFT(DIR_SHIFT)) chk_i (
      .entry(entry_q), .is_write(wr_q), .cpl(cpl_q), .code(chk_code)
   );

   pde_update #(.PAGE_SHIFT(PAGE_SHIFT), .DIR_SHIFT(DIR_SHIFT)) upd_i (
      .entry(entry_q), .lin(lin_q), .is_write(wr_q), .code(chk_code),
      .new_entry(upd_entry), .need_wb(upd_wb), .kind(upd_kind),
      .res_addr(upd_addr), .attr(upd_attr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_IDLE;
         lin_q      <= '0;
         wr_q       <= 1'b0;
         cpl_q      <= '0;
         ent_addr_q <= '0;
         entry_q    <= '0;
         wdata_q    <= '0;
         code_q     <= FLT_NONE;
         kind_q     <= RK_BIG;
         res_addr_q <= '0;
         attr_q     <= '0;
      end else begin
         case (st_q)
            ST_IDLE: if (req_valid) begin
               lin_q      <= req_lin_addr;
               wr_q       <= req_write;
               cpl_q      <= req_cpl;
               ent_addr_q <= ent_addr_d;
               st_q       <= ST_RD;
            end
            ST_RD: if (mem_ack) begin
               entry_q <= mem_rdata;
               st_q    <= ST_EVAL;
            end
            ST_EVAL: begin
               code_q     <= chk_code;
               kind_q     <= upd_kind;
               res_addr_q <= upd_addr;
               attr_q     <= upd_attr;
               wdata_q    <= upd_entry;
               st_q       <= upd_wb ? ST_WR : ST_DONE;
            end
            ST_WR: if (mem_ack) st_q <= ST_DONE;
            ST_DONE: st_q <= ST_IDLE;
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign mem_req    = (st_q == ST_RD) || (st_q == ST_WR);
   assign mem_we     = (st_q == ST_WR);
   assign mem_addr   = ent_addr_q;
   assign mem_wdata  = wdata_q;
   assign done       = (st_q == ST_DONE);
   assign res_kind   = kind_q;
   assign res_addr   = res_addr_q;
   assign fault_code = code_q;
   assign attr_out   = attr_q;

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R1
   AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (mem_addr[1:0] == 2'b00)); // R1
   AST_FAULT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (chk_code == FLT_NONE)); // R11
   AST_WB_SETS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> mem_wdata[BIT_ACC]); // R9
   AST_WB_KEEPS_BITS: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> ((mem_wdata & ~32'h60) == (entry_q & ~32'h60))); // R12
   AST_SMALL_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && !entry_q[BIT_BIG]) |-> (mem_wdata[BIT_DIRTY] == entry_q[BIT_DIRTY])); // R10
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R13
   AST_FAULT_KIND: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ((res_kind == RK_FAULT) == (fault_code != FLT_NONE))); // R8
   AST_NO_REQ_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !mem_req); // R11
endmodule

// File: tb/pde_walker_tb_top.sv
module pde_walker_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_lin_addr = '0;
   logic        req_write = 1'b0;
   logic [1:0]  req_cpl = '0;
   logic [31:0] dir_base = '0;
   logic        mem_req, mem_we, done;
   logic [31:0] mem_addr, mem_wdata, res_addr;
   logic [31:0] mem_rdata = '0;
   logic        mem_ack = 1'b0;
   logic [1:0]  res_kind;
   logic [2:0]  fault_code;
   logic [5:0]  attr_out;

   int total = 0;
   int bad = 0;
   int rd_cnt = 0;
   int wr_cnt = 0;
   logic [31:0] last_addr = '0;
   logic [31:0] mem [0:1023];

   always #10 clk = ~clk;

   pde_walker dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_lin_addr(req_lin_addr),
      .req_write(req_write), .req_cpl(req_cpl), .dir_base(dir_base),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .mem_ack(mem_ack), .done(done), .res_kind(res_kind),
      .res_addr(res_addr), .fault_code(fault_code), .attr_out(attr_out)
   );

   always @(posedge clk) begin
      mem_ack <= 1'b0;
      if (mem_req && !mem_ack) begin
         mem_ack   <= 1'b1;
         last_addr <= mem_addr;
         mem_rdata <= mem[mem_addr[11:2]];
         if (mem_we) begin
            mem[mem_addr[11:2]] <= mem_wdata;
            wr_cnt <= wr_cnt + 1;
         end else begin
            rd_cnt <= rd_cnt + 1;
         end
      end
   end

   task automatic check(input string req, input logic ok, input logic [31:0] act,
                        input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [2:0] m_code(input logic [31:0] e, input logic w,
                                         input logic [1:0] c);
      if (!e[0]) return 3'd1;
      if (e[7] && (e[21:12] != 0)) return 3'd2;
      if (e[2] && c == 2'd3) return 3'd3;
      if (w && !e[1]) return 3'd4;
      return 3'd0;
   endfunction

   task automatic wait_done(output logic seen);
      seen = 1'b0;
      for (int i = 0; i < 40 && !seen; i++) begin
         @(negedge clk);
         if (done) seen = 1'b1;
      end
   endtask

   // one access, every result checked against the model built from the requirements
   task automatic do_access(input string tag, input logic [31:0] base, input logic [31:0] lin,
                            input logic w, input logic [1:0] c, input logic [31:0] e);
      logic [31:0] exp_ea, exp_new, exp_addr;
      logic [2:0]  exp_code;
      logic [1:0]  exp_kind;
      logic        exp_wb, seen;
      int          wr0;
      exp_ea   = {base[31:12], lin[31:22], 2'b00};
      exp_code = m_code(e, w, c);
      exp_new  = e;
      if (exp_code == 0) begin
         exp_new[5] = 1'b1;
         if (e[7] && w) exp_new[6] = 1'b1;
      end
      exp_wb   = (exp_new != e);
      exp_kind = (exp_code != 0) ? 2'd2 : (e[7] ? 2'd0 : 2'd1);
      exp_addr = (exp_code != 0) ? 32'h0 :
                 (e[7] ? {e[31:22], lin[21:0]} : {e[31:12], 12'h000});
      mem[lin[31:22]] = e;
      wr0 = wr_cnt;
      @(negedge clk);
      dir_base = base; req_lin_addr = lin; req_write = w; req_cpl = c; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      wait_done(seen);
      check({tag, " done seen"}, seen, {31'd0, seen}, 32'd1);
      check({tag, " R1 entry address"}, last_addr == exp_ea, last_addr, exp_ea);
      check({tag, " R8 code"}, fault_code == exp_code, {29'd0, fault_code}, {29'd0, exp_code});
      check({tag, " kind"}, res_kind == exp_kind, {30'd0, res_kind}, {30'd0, exp_kind});
      check({tag, " addr"}, res_addr == exp_addr, res_addr, exp_addr);
      check({tag, " R11 write count"}, (wr_cnt - wr0) == (exp_wb ? 1 : 0), wr_cnt - wr0,
            exp_wb ? 1 : 0);
      check({tag, " R9 R10 R12 stored entry"}, mem[lin[31:22]] == exp_new,
            mem[lin[31:22]], exp_new);
      if (exp_code == 0)
         check({tag, " R12 attr"}, attr_out == {e[11:9], e[8], e[4], e[3]},
               {26'd0, attr_out}, {26'd0, e[11:9], e[8], e[4], e[3]});
      @(negedge clk);
      check({tag, " R13 done one cycle"}, !done, {31'd0, done}, 32'd0);
   endtask

   task automatic t_reset;
      check("R13 reset done", done == 1'b0, {31'd0, done}, 32'd0);
      check("R13 reset mem_req", mem_req == 1'b0, {31'd0, mem_req}, 32'd0);
   endtask

   task automatic t_large;
      do_access("R3 large read", 32'h0012_3ABC, 32'h0C81_2345, 1'b0, 2'd0, 32'hA540_0083);
      do_access("R10 large write", 32'h0012_3000, 32'hFFC0_0010, 1'b1, 2'd3, 32'h1240_0083);
      do_access("R11 large acc set read", 32'h0077_7FFF, 32'h4000_0004, 1'b0, 2'd1, 32'h8000_00A1);
      do_access("R11 large write dirty needed", 32'h0, 32'h4040_0000, 1'b1, 2'd0, 32'h8000_00A3);
      do_access("R11 large all set", 32'h0, 32'h4080_0000, 1'b1, 2'd0, 32'h8000_00E3);
   endtask

   task automatic t_small;
      do_access("R4 small read", 32'h0001_0000, 32'h0340_0FFF, 1'b0, 2'd0, 32'h5678_9001);
      do_access("R10 small write d0", 32'h0, 32'h0380_0000, 1'b1, 2'd0, 32'h1111_1003);
      do_access("R10 small write d1", 32'h0, 32'h03C0_0000, 1'b1, 2'd0, 32'h1111_1043);
      do_access("R12 attr pass", 32'h0, 32'h0400_0000, 1'b0, 2'd2, 32'h2222_2F1D);
   endtask

   task automatic t_faults;
      do_access("R2 absent", 32'h0, 32'h0800_0000, 1'b1, 2'd3, 32'hFFFF_FFFE);
      do_access("R5 reserved", 32'h0, 32'h0840_0000, 1'b0, 2'd0, 32'h8000_1083);
      do_access("R8 reserved over priv", 32'h0, 32'h0880_0000, 1'b1, 2'd3, 32'h8020_0085);
      do_access("R6 priv", 32'h0, 32'h08C0_0000, 1'b0, 2'd3, 32'h3000_0007);
      do_access("R6 priv lvl2 ok", 32'h0, 32'h0900_0000, 1'b0, 2'd2, 32'h3000_0007);
      do_access("R7 write protect", 32'h0, 32'h0940_0000, 1'b1, 2'd0, 32'h3000_0001);
      do_access("R7 read ro ok", 32'h0, 32'h0980_0000, 1'b0, 2'd3, 32'h3000_0001);
      do_access("R8 priv over wp", 32'h0, 32'h09C0_0000, 1'b1, 2'd3, 32'h3000_0085);
   endtask

   // R13: request pulses while busy are dropped
   task automatic t_busy;
      logic seen;
      int   r0, w0;
      mem[10'h0A0] = 32'h0000_5003;
      mem[10'h0A1] = 32'h0000_6003;
      r0 = rd_cnt; w0 = wr_cnt;
      @(negedge clk);
      dir_base = 32'h0; req_lin_addr = 32'h2800_0000; req_write = 1'b0; req_cpl = 2'd0;
      req_valid = 1'b1;
      @(negedge clk);
      req_lin_addr = 32'h2840_0000;
      @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      wait_done(seen);
      check("R13 busy first result", res_addr == 32'h0000_5000, res_addr, 32'h0000_5000);
      @(negedge clk);
      @(negedge clk);
      @(negedge clk);
      check("R13 busy reads", (rd_cnt - r0) == 1, rd_cnt - r0, 1);
      check("R13 busy writes", (wr_cnt - w0) == 1, wr_cnt - w0, 1);
      check("R13 busy other entry kept", mem[10'h0A1] == 32'h0000_6003, mem[10'h0A1],
            32'h0000_6003);
   endtask

   bit finished = 1'b0;

   initial begin
      for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_large();
      t_small();
      t_faults();
      t_busy();
      if (!finished) begin
         finished = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule